// File: doc/BRIEF.md
# Bus Timeout Checker

This block is a passive observer for a pipelined memory-mapped bus. It sees the bus signals: command strobes for read and write, a stall input from the target, a read-data-valid strobe, a burst length and a word address. It drives none of them. It keeps a small in-order record of the reads that are still waiting for data and the number of beats each one still owes. It runs three separate cycle counters: one for an unbroken target stall, one for a silent read response and one for an unfinished write burst.

When a limit is broken, or the bus breaks an ordering rule, the block sets a sticky error flag. There is one output for each kind of fault. The rules cover the pending-read limit, response beats that no read asked for, misaligned burst starts and write-burst beat addresses. All flags stay set until a synchronous clear pulse or a reset. The block is placed beside a bus in simulation or in silicon, and its flags are routed to whatever collects faults.

Top module: `mmWatch`

## Requirements
- R1: When `busWait` has been high for STALL_LIMIT+1 consecutive cycles, `errStall` is set at the end of that cycle. A run of exactly STALL_LIMIT high cycles sets nothing.
- R2: While at least one accepted read still owes beats, `errRdLate` is set when RD_LIMIT consecutive cycles pass with `busRdValid` low. The count starts in the cycle after the read is accepted and restarts on every valid beat. A beat that arrives in the RD_LIMIT-th cycle prevents the error.
- R3: The first accepted beat of a write burst with length above one starts a timer. The last beat must be accepted within the next WR_LIMIT cycles. If it is not, `errWrLate` is set at the end of the WR_LIMIT-th cycle.
- R4: An accepted read that arrives while MAX_PEND reads are already pending, and while no pending read completes in that same cycle, sets `errRdOverrun`. That read is not recorded and adds no expected beats.
- R5: A `busRdValid` beat that arrives when no accepted read owes any beat sets `errRdStray`.
- R6: A read of burst length N owes N valid beats, with length 0 counted as 1. Beats are charged to the reads in order of acceptance.
- R7: In the default wrapping mode, a write burst of power-of-two length N covers the N-word window that starts at its first address rounded down to a multiple of N. Each later beat must carry the previous beat's address plus one, taken modulo the window; otherwise `errBeatAddr` is set. Non-power-of-two lengths are not checked in this mode. With wrapping off, each later beat must carry the previous address plus one.
- R8: With alignment checking on (the default), an accepted read, or the first beat of a write burst, whose length N is a power of two and whose address is not a multiple of N sets `errMisalign`.
- R9: Every error flag stays set until `errClr` is high at a clock edge. That edge clears all flags, and the clear wins over any fault detected in the same cycle.
- R10: A synchronous `rst` clears all flags, the pending-read record and all timers.
- R11: A read or write is accepted only in a cycle where its strobe is high and `busWait` is low. A strobe seen while `busWait` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| errClr | input | 1 | Synchronous clear of all error flags |
| busAddr | input | ADDR_W | Word address on the bus |
| busBurst | input | BURST_W | Burst length of the command (0 counts as 1) |
| busRead | input | 1 | Read command strobe |
| busWrite | input | 1 | Write command strobe |
| busWait | input | 1 | Target stall; commands are not accepted while high |
| busRdValid | input | 1 | One read data beat returned |
| errStall | output | 1 | Stall run too long (sticky) |
| errRdLate | output | 1 | Read response too late (sticky) |
| errWrLate | output | 1 | Write burst not finished in time (sticky) |
| errRdOverrun | output | 1 | Too many pending reads (sticky) |
| errRdStray | output | 1 | Valid beat with nothing pending (sticky) |
| errMisalign | output | 1 | Burst start not aligned to its length (sticky) |
| errBeatAddr | output | 1 | Write beat address out of sequence (sticky) |

## Verification
Every fault decision is made from the current bus cycle and registered state, so each flag becomes visible exactly one clock after the cycle that broke the rule. The bench changes the inputs just after a falling edge and reads the flags at the next falling edge. After each cycle it compares all seven flags with a cycle-stepped bench model. The directed timeout cases count cycles from the accepting edge, and each one probes both the last cycle that is still legal and the first cycle that is not.

// File: rtl/mmWatchPkg.sv
`timescale 1ns/1ps
package mmWatchPkg;

  // strobes decoded by the control for the datapath
  typedef struct packed {
    logic wrStart;
    logic wrBeat;
    logic rdvBeat;
    logic popRd;
    logic pushRd;
  } strobe_t;

  // conditions reported by the datapath to the control
  typedef struct packed {
    logic anyPend;
    logic fifoFull;
    logic headLast;
    logic wrActive;
    logic stallHit;
    logic rdHit;
    logic wrHit;
    logic beatAddrBad;
    logic misaligned;
  } status_t;

  typedef struct packed {
    logic stall;
    logic rdLate;
    logic wrLate;
    logic rdOverrun;
    logic rdStray;
    logic misalign;
    logic beatAddr;
  } errs_t;

endpackage

// File: rtl/mmWatchData.sv
`timescale 1ns/1ps
module mmWatchData
  import mmWatchPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BURST_W     = 4,
  parameter int STALL_LIMIT = 1024,
  parameter int RD_LIMIT    = 100,
  parameter int WR_LIMIT    = 100,
  parameter int MAX_PEND    = 1,
  parameter bit WRAP_BURST  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BURST_W-1:0] busBurst,
  input  logic               busWait,
  input  logic               busRdValid,
  input  strobe_t            stb,
  output status_t            sts
);

  localparam int STALL_W = $clog2(STALL_LIMIT + 2);
  localparam int RDT_W   = $clog2(RD_LIMIT + 1);
  localparam int WRT_W   = $clog2(WR_LIMIT + 2);
  localparam int IDX_W   = (MAX_PEND > 1) ? $clog2(MAX_PEND) : 1;
  localparam int CNT_W   = $clog2(MAX_PEND + 1);
  localparam int SLOTS   = 2 ** IDX_W;

  // burst length decode
  logic [BURST_W-1:0] effBurst;
  logic [ADDR_W-1:0]  burstMask;
  logic               isPow2;

  assign effBurst  = (busBurst == '0) ? BURST_W'(1) : busBurst;
  assign burstMask = ADDR_W'(effBurst) - ADDR_W'(1);
  assign isPow2    = (effBurst & (effBurst - 1'b1)) == '0;

  // pending read record: one length per read, oldest first
  logic [BURST_W-1:0] lenMem [SLOTS];
  logic [IDX_W-1:0]   wrIdx, rdIdx;
  logic [CNT_W-1:0]   count;
  logic [BURST_W-1:0] headGot;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(MAX_PEND - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      count   <= '0;
      headGot <= '0;
    end else begin
      if (stb.pushRd) wrIdx <= bump(wrIdx);
      if (stb.popRd) begin
        rdIdx   <= bump(rdIdx);
        headGot <= '0;
      end else if (stb.rdvBeat) begin
        headGot <= headGot + 1'b1;
      end
      case ({stb.pushRd, stb.popRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stb.pushRd) lenMem[wrIdx] <= effBurst;
  end

  // stall run counter
  logic [STALL_W-1:0] stallCnt;
  always_ff @(posedge clk) begin
    if (rst || !busWait) stallCnt <= '0;
    else if (stallCnt <= STALL_W'(STALL_LIMIT)) stallCnt <= stallCnt + 1'b1;
  end

  // silent-response counter
  logic [RDT_W-1:0] rdTimer;
  always_ff @(posedge clk) begin
    if (rst || count == '0 || busRdValid) rdTimer <= '0;
    else if (rdTimer < RDT_W'(RD_LIMIT)) rdTimer <= rdTimer + 1'b1;
  end

  // write burst tracking
  logic               wrActive, wrChk;
  logic [BURST_W-1:0] wrLeft;
  logic [WRT_W-1:0]   wrTimer;
  logic [ADDR_W-1:0]  wrMask, expAddr, selMask, nextAddr, incAddr;

  assign selMask = wrActive ? wrMask : burstMask;
  assign incAddr = busAddr + 1'b1;

  generate
    if (WRAP_BURST) begin : g_wrap
      assign nextAddr = (busAddr & ~selMask) | (incAddr & selMask);
    end else begin : g_incr
      assign nextAddr = incAddr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wrActive <= 1'b0;
      wrChk    <= 1'b0;
      wrLeft   <= '0;
      wrTimer  <= '0;
      wrMask   <= '0;
      expAddr  <= '0;
    end else begin
      if (stb.wrStart) begin
        if (effBurst > BURST_W'(1)) begin
          wrActive <= 1'b1;
          wrLeft   <= effBurst - 1'b1;
          wrTimer  <= WRT_W'(1);
          wrMask   <= isPow2 ? burstMask : '0;
          wrChk    <= !WRAP_BURST || isPow2;
          expAddr  <= nextAddr;
        end
      end else begin
        if (wrActive && wrTimer <= WRT_W'(WR_LIMIT)) wrTimer <= wrTimer + 1'b1;
        if (stb.wrBeat) begin
          wrLeft  <= wrLeft - 1'b1;
          expAddr <= nextAddr;
          if (wrLeft == BURST_W'(1)) wrActive <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sts.anyPend     = count != '0;
    sts.fifoFull    = count == CNT_W'(MAX_PEND);
    sts.headLast    = ({1'b0, headGot} + 1'b1) == {1'b0, lenMem[rdIdx]};
    sts.wrActive    = wrActive;
    sts.stallHit    = busWait && stallCnt == STALL_W'(STALL_LIMIT);
    sts.rdHit       = (count != '0) && !busRdValid && rdTimer == RDT_W'(RD_LIMIT - 1);
    sts.wrHit       = wrActive && wrTimer == WRT_W'(WR_LIMIT)
                      && !(stb.wrBeat && wrLeft == BURST_W'(1));
    sts.beatAddrBad = wrChk && busAddr != expAddr;
    sts.misaligned  = isPow2 && (busAddr & burstMask) != '0;
  end

  // R4
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(MAX_PEND));

  // R6
  pop_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    stb.popRd |-> count != '0);

  // R3
  wr_timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wrTimer <= WRT_W'(WR_LIMIT + 1));

endmodule

// File: rtl/mmWatchCtrl.sv
`timescale 1ns/1ps
module mmWatchCtrl
  import mmWatchPkg::*;
#(
  parameter bit ALIGN_BURST = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    errClr,
  input  logic    busRead,
  input  logic    busWrite,
  input  logic    busWait,
  input  logic    busRdValid,
  input  status_t sts,
  output strobe_t stb,
  output errs_t   errs
);

  logic  rdAcc, wrAcc, rdvBeat, popRd, overrun, wrStart, wrBeat;
  errs_t setNow;

  always_comb begin
    rdAcc   = busRead && !busWait;
    wrAcc   = busWrite && !busWait;
    rdvBeat = busRdValid && sts.anyPend;
    popRd   = rdvBeat && sts.headLast;
    overrun = rdAcc && sts.fifoFull && !popRd;
    wrStart = wrAcc && !sts.wrActive;
    wrBeat  = wrAcc && sts.wrActive;

    stb.wrStart = wrStart;
    stb.wrBeat  = wrBeat;
    stb.rdvBeat = rdvBeat;
    stb.popRd   = popRd;
    stb.pushRd  = rdAcc && !overrun;

    setNow.stall     = sts.stallHit;
    setNow.rdLate    = sts.rdHit;
    setNow.wrLate    = sts.wrHit;
    setNow.rdOverrun = overrun;
    setNow.rdStray   = busRdValid && !sts.anyPend;
    setNow.misalign  = ALIGN_BURST && sts.misaligned && (rdAcc || wrStart);
    setNow.beatAddr  = wrBeat && sts.beatAddrBad;
  end

  always_ff @(posedge clk) begin
    if (rst || errClr) errs <= '0;
    else errs <= errs | setNow;
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!errClr && errs != '0) |=> ((errs & $past(errs)) == $past(errs)));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    errClr |=> errs == '0);

  // R1
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(errs.stall) |-> $past(busWait));

endmodule

// File: rtl/mmWatch.sv
`timescale 1ns/1ps
module mmWatch
  import mmWatchPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BURST_W     = 4,
  parameter int STALL_LIMIT = 1024,
  parameter int RD_LIMIT    = 100,
  parameter int WR_LIMIT    = 100,
  parameter int MAX_PEND    = 1,
  parameter bit WRAP_BURST  = 1'b1,
  parameter bit ALIGN_BURST = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               errClr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BURST_W-1:0] busBurst,
  input  logic               busRead,
  input  logic               busWrite,
  input  logic               busWait,
  input  logic               busRdValid,
  output logic               errStall,
  output logic               errRdLate,
  output logic               errWrLate,
  output logic               errRdOverrun,
  output logic               errRdStray,
  output logic               errMisalign,
  output logic               errBeatAddr
);

  strobe_t stb;
  status_t sts;
  errs_t   errs;

  mmWatchCtrl #(
    .ALIGN_BURST(ALIGN_BURST)
  ) i_ctrl (
    .clk(clk), .rst(rst), .errClr(errClr),
    .busRead(busRead), .busWrite(busWrite), .busWait(busWait),
    .busRdValid(busRdValid), .sts(sts), .stb(stb), .errs(errs)
  );

  mmWatchData #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .STALL_LIMIT(STALL_LIMIT),
    .RD_LIMIT(RD_LIMIT), .WR_LIMIT(WR_LIMIT), .MAX_PEND(MAX_PEND),
    .WRAP_BURST(WRAP_BURST)
  ) i_data (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busBurst(busBurst),
    .busWait(busWait), .busRdValid(busRdValid), .stb(stb), .sts(sts)
  );

  assign errStall     = errs.stall;
  assign errRdLate    = errs.rdLate;
  assign errWrLate    = errs.wrLate;
  assign errRdOverrun = errs.rdOverrun;
  assign errRdStray   = errs.rdStray;
  assign errMisalign  = errs.misalign;
  assign errBeatAddr  = errs.beatAddr;

  // R5
  stray_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (busRdValid && !sts.anyPend && !errClr) |=> errRdStray);

  // R10
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (errs == '0));

endmodule

// File: tb/test_mmWatch.sv
`timescale 1ns/1ps
module test_mmWatch;

  localparam int AW = 12, BW = 4, SL = 8, RL = 6, WL = 5, MP = 2;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] bc = '0;
  logic rd = 1'b0, wr = 1'b0, wt = 1'b0, rdv = 1'b0;
  logic fStall, fRdLate, fWrLate, fOver, fStray, fMis, fBeat;
  logic [6:0] dutF;
  assign dutF = {fStall, fRdLate, fWrLate, fOver, fStray, fMis, fBeat};

  mmWatch #(
    .ADDR_W(AW), .BURST_W(BW), .STALL_LIMIT(SL), .RD_LIMIT(RL),
    .WR_LIMIT(WL), .MAX_PEND(MP), .WRAP_BURST(1'b1), .ALIGN_BURST(1'b1)
  ) i_mmWatch (
    .clk(clk), .rst(rst), .errClr(clr), .busAddr(addr), .busBurst(bc),
    .busRead(rd), .busWrite(wr), .busWait(wt), .busRdValid(rdv),
    .errStall(fStall), .errRdLate(fRdLate), .errWrLate(fWrLate),
    .errRdOverrun(fOver), .errRdStray(fStray), .errMisalign(fMis),
    .errBeatAddr(fBeat)
  );

  always #10 clk = ~clk;  // 20 ns period

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  int mPend[$];
  int mGot, mStall, mSilent, mWrLeft, mWrT, mWrMask, mExp;
  bit mWrOn, mWrChk;
  bit [6:0] expF;

  function automatic string tagOf(int b);
    case (b)
      6: return "R1 stall";
      5: return "R2 rdLate";
      4: return "R3 wrLate";
      3: return "R4 overrun";
      2: return "R5 stray";
      1: return "R8 misalign";
      default: return "R7 beatAddr";
    endcase
  endfunction

  function automatic int wrapNext(int a, int m);
    return ((a & ~m) | ((a + 1) & m)) & 12'hFFF;
  endfunction

  task automatic modelReset();
    mPend.delete();
    mGot = 0; mStall = 0; mSilent = 0; mWrLeft = 0; mWrT = 0;
    mWrMask = 0; mExp = 0; mWrOn = 0; mWrChk = 0; expF = '0;
  endtask

  task automatic modelStep(bit r, bit w, bit t, bit v, int a, int b, bit c);
    bit rdA, wrA, p2, pop, sOv;
    int eb, sz;
    bit [6:0] s;
    rdA = r && !t;
    wrA = w && !t;
    eb  = (b == 0) ? 1 : b;
    p2  = (eb & (eb - 1)) == 0;
    sz  = mPend.size();
    pop = v && sz > 0 && (mGot + 1 == mPend[0]);
    sOv = rdA && sz == MP && !pop;
    s[6] = t && mStall == SL;
    s[5] = sz > 0 && !v && mSilent == RL - 1;
    s[4] = mWrOn && mWrT == WL && !(wrA && mWrLeft == 1);
    s[3] = sOv;
    s[2] = v && sz == 0;
    s[1] = p2 && ((a & (eb - 1)) != 0) && (rdA || (wrA && !mWrOn));
    s[0] = wrA && mWrOn && mWrChk && a != mExp;
    mStall  = t ? ((mStall < SL + 1) ? mStall + 1 : mStall) : 0;
    mSilent = (sz == 0 || v) ? 0 : ((mSilent < RL) ? mSilent + 1 : mSilent);
    if (v && sz > 0) begin
      if (pop) begin void'(mPend.pop_front()); mGot = 0; end
      else mGot++;
    end
    if (rdA && !sOv) mPend.push_back(eb);
    if (wrA && !mWrOn) begin
      if (eb > 1) begin
        mWrOn = 1; mWrLeft = eb - 1; mWrT = 1;
        mWrMask = p2 ? eb - 1 : 0; mWrChk = p2;
        mExp = wrapNext(a, eb - 1);
      end
    end else begin
      if (mWrOn && mWrT <= WL) mWrT++;
      if (wrA && mWrOn) begin
        mWrLeft--;
        mExp = wrapNext(a, mWrMask);
        if (mWrLeft == 0) mWrOn = 0;
      end
    end
    expF = c ? 7'b0 : (expF | s);
  endtask

  task automatic cmpAll();
    for (int b = 0; b < 7; b++) begin
      checks++;
      if (dutF[b] !== expF[b]) begin
        fails++;
        $display("FAIL %s: actual %0b expected %0b at %0t", tagOf(b), dutF[b], expF[b], $time);
      end
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // call just after a falling edge; returns at the next falling edge
  task automatic drive(bit r, bit w, bit t, bit v, int a, int b, bit c);
    rd = r; wr = w; wt = t; rdv = v; addr = AW'(a); bc = BW'(b); clr = c;
    modelStep(r, w, t, v, a, b, c);
    @(negedge clk);
    cmpAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit stallPh, r, w, t, v, c;
    int a, b, gLeft, gMask, gNext, gb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 flags in reset", |dutF, 1'b0);
    rst = 1'b0;
    modelReset();

    // R1: exactly SL stall cycles pass, one more fails
    repeat (SL) drive(0, 0, 1, 0, 0, 1, 0);
    chk("R1 stall at limit", fStall, 1'b0);
    drive(0, 0, 1, 0, 0, 1, 0);
    chk("R1 stall past limit", fStall, 1'b1);
    idle(3);
    chk("R9 sticky stall", fStall, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 1);
    chk("R9 cleared", |dutF, 1'b0);

    // R11: read during stall is not accepted, so the later beat is stray
    drive(1, 0, 1, 0, 0, 1, 0);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R11 R5 stray after stalled read", fStray, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 1);

    // R2: late response
    drive(1, 0, 0, 0, 0, 1, 0);
    idle(RL - 1);
    chk("R2 before limit", fRdLate, 1'b0);
    idle(1);
    chk("R2 at limit", fRdLate, 1'b1);
    drive(0, 0, 0, 1, 0, 1, 1);
    // R2: beat in the last legal cycle
    drive(1, 0, 0, 0, 0, 1, 0);
    idle(RL - 1);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R2 beat just in time", fRdLate, 1'b0);
    chk("R6 single beat consumed", fStray, 1'b0);

    // R6: burst of 3 owes 3 beats
    drive(1, 0, 0, 0, 0, 3, 0);
    repeat (3) drive(0, 0, 0, 1, 0, 1, 0);
    chk("R6 three beats expected", fStray, 1'b0);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R6 fourth beat stray", fStray, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 1);
    // R6: length 0 counts as one
    drive(1, 0, 0, 0, 5, 0, 0);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R6 zero length one beat", fStray, 1'b0);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R6 zero length second beat", fStray, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 1);

    // R4: pending limit
    drive(1, 0, 0, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 0, 1, 0);
    chk("R4 at limit", fOver, 1'b0);
    drive(1, 0, 0, 0, 0, 1, 0);
    chk("R4 over limit", fOver, 1'b1);
    drive(0, 0, 0, 1, 0, 1, 0);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R4 recorded reads drained", fStray, 1'b0);
    drive(0, 0, 0, 1, 0, 1, 0);
    chk("R4 excess read not recorded", fStray, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 1);

    // R3: write burst finishing on the last legal cycle
    drive(0, 1, 0, 0, 4, 4, 0);
    drive(0, 1, 0, 0, 5, 4, 0);
    drive(0, 1, 0, 0, 6, 4, 0);
    idle(2);
    drive(0, 1, 0, 0, 7, 4, 0);
    chk("R3 finish in time", fWrLate, 1'b0);
    // R3: one cycle too late
    drive(0, 1, 0, 0, 8, 4, 0);
    drive(0, 1, 0, 0, 9, 4, 0);
    drive(0, 1, 0, 0, 10, 4, 0);
    idle(3);
    chk("R3 late burst", fWrLate, 1'b1);
    drive(0, 1, 0, 0, 11, 4, 0);
    chk("R7 incrementing inside window", fBeat, 1'b0);
    drive(0, 0, 0, 0, 0, 1, 1);

    // R7/R8: wrapped burst starting mid-window
    drive(0, 1, 0, 0, 10, 4, 0);
    chk("R8 misaligned write start", fMis, 1'b1);
    drive(0, 1, 0, 0, 11, 4, 0);
    drive(0, 1, 0, 0, 8, 4, 0);
    drive(0, 1, 0, 0, 9, 4, 0);
    chk("R7 wrap sequence ok", fBeat, 1'b0);
    drive(0, 0, 0, 0, 0, 1, 1);
    drive(0, 1, 0, 0, 10, 4, 0);
    drive(0, 1, 0, 0, 11, 4, 0);
    drive(0, 1, 0, 0, 12, 4, 0);
    chk("R7 crossed window", fBeat, 1'b1);
    drive(0, 1, 0, 0, 9, 4, 0);
    drive(0, 0, 0, 0, 0, 1, 1);

    // R8: read alignment
    drive(1, 0, 0, 0, 3, 2, 0);
    chk("R8 misaligned read", fMis, 1'b1);
    drive(0, 0, 0, 1, 0, 1, 1);
    drive(0, 0, 0, 1, 0, 1, 0);
    drive(1, 0, 0, 0, 4, 2, 0);
    drive(1, 0, 0, 0, 6, 3, 0);
    chk("R8 aligned and odd length", fMis, 1'b0);
    repeat (5) drive(0, 0, 0, 1, 0, 1, 0);
    chk("R6 mixed lengths drained", fStray, 1'b0);

    // R9: clear wins over a fault in the same cycle
    drive(0, 0, 0, 1, 0, 1, 1);
    chk("R9 clear beats new fault", fStray, 1'b0);

    // constrained random phase
    stallPh = 0; gLeft = 0; gMask = 0; gNext = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 150 == 0) stallPh = !stallPh;
      t = ($urandom % 100) < (stallPh ? 96 : 30);
      c = ($urandom % 30) == 0;
      v = (mPend.size() > 0) ? (($urandom % 10) < 7) : (($urandom % 40) == 0);
      r = 0; w = 0;
      if (gLeft > 0) begin
        w = ($urandom % 3) != 0;
        a = (($urandom % 10) == 0) ? int'($urandom % 4096) : gNext;
        b = gb;
      end else if (($urandom % 4) == 0) begin
        w = 1;
        case ($urandom % 5)
          0: gb = 1; 1: gb = 2; 2: gb = 4; 3: gb = 8; default: gb = 3;
        endcase
        b = gb;
        a = $urandom % 4096;
        if (($urandom % 4) != 0 && (gb & (gb - 1)) == 0) a = a & ~(gb - 1);
      end else begin
        r = ($urandom % 3) == 0;
        b = $urandom % 7;
        a = $urandom % 4096;
        if (($urandom % 4) != 0 && b > 0 && (b & (b - 1)) == 0) a = a & ~(b - 1);
      end
      drive(r, w, t, v, a, b, c);
      if (w && !t) begin
        if (gLeft == 0) begin
          if (gb > 1) begin
            gLeft = gb - 1;
            gMask = ((gb & (gb - 1)) == 0) ? gb - 1 : 0;
            gNext = wrapNext(a, gMask);
          end
        end else begin
          gLeft--;
          gNext = wrapNext(a, gMask);
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule